// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block holds the interrupt status of a general-purpose timer that has four match channels and four capture channels. Each enabled match or capture event raises its own flag bit, so software can tell which source caused the interrupt. Software clears flags with write-one-to-clear writes. The OR of all flags drives a single registered interrupt line.

The match comparators, the capture latches and the counter are outside the block. They appear here only as one-cycle event pulses with an enable bit for each channel. The main duty of the block is to keep every event across software accesses. A hardware set that lands in the same cycle as a clear write, on another bit or on the same bit, is never lost. A channel that took part in such a collision keeps raising interrupts afterwards.

The write port is a plain single-cycle strobe with no back-pressure. A write is taken on every clock edge where `wr_en` is high, and the block never stalls.

Top module: `timer_irq_flags`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `flags` is 0 and `irq` is 0.
- R2: Flag bit i (i = 0..3) belongs to match channel i, and flag bit 4+i belongs to capture channel i. A pulse on an event input whose enable is 1 makes the matching flag bit 1 after the next rising clock edge.
- R3: An event pulse whose enable is 0 never sets its flag bit.
- R4: A clock edge with `wr_en` = 1 clears every flag bit whose `wr_data` bit is 1, unless that bit is being set in the same cycle.
- R5: `wr_data` bits that are 0 leave their flags unchanged. A write with `wr_en` = 0 changes nothing.
- R6: A clear of one bit (for example bit 0) in the same cycle as an enabled event on another bit (for example bit 1) leaves the other bit set.
- R7: An enabled event and a clear on the same bit in the same cycle leave that bit set.
- R8: An enabled capture event in the same cycle as a write that clears match flags is still recorded in its capture flag.
- R9: `irq` is the registered OR of all flag bits, computed from the same next-state value and therefore updating on the same edge as `flags`.
- R10: After a coincident set and clear, later events on the same channel set the flag again once software has cleared it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| match_evt | input | 4 | One-cycle event pulses from the match channels |
| match_ie | input | 4 | Interrupt enable for each match channel |
| cap_evt | input | 4 | One-cycle event pulses from the capture channels |
| cap_ie | input | 4 | Interrupt enable for each capture channel |
| wr_en | input | 1 | Write strobe for the flag register |
| wr_data | input | 8 | Write-one-to-clear mask; bits 3:0 are match, bits 7:4 are capture |
| flags | output | 8 | Current flag bits |
| irq | output | 1 | Registered OR of the flags |

## Verification
The assertions check the following on every cycle:
- an enabled event always shows up in its flag on the next cycle, whatever is written;
- a bit rises only after an enabled set;
- a bit that is cleared and not set falls;
- bits that are neither set nor cleared stay as they were;
- `irq` always equals the OR of the flags.

Only the bench scenarios show the full mapping from a starting flag pattern, a clear mask and a set of gated events to the resulting register value. The bench sweeps every clear mask against a range of starting patterns. The named collision cases (bit 0 cleared while bit 1 is set, capture during a match clear, and re-raising the same channel after a collision) are also run as scenarios.

// File: rtl/tif_pkg.sv
package tif_pkg;
  localparam int unsigned DEF_MATCH = 4;
  localparam int unsigned DEF_CAP   = 4;

  typedef struct packed {
    logic set;
    logic clr;
  } bit_cmd_t;

  // Set has priority over clear so that a coincident event is kept.
  function automatic logic flag_next(input logic q, input bit_cmd_t cmd);
    return cmd.set | (q & ~cmd.clr);
  endfunction
endpackage

// File: rtl/tif_evt_gate.sv
module tif_evt_gate #(
  parameter int unsigned NUM_MATCH = 4,
  parameter int unsigned NUM_CAP   = 4,
  localparam int unsigned NUM_FLAGS = NUM_MATCH + NUM_CAP
) (
  input  logic [NUM_MATCH-1:0] match_evt,
  input  logic [NUM_MATCH-1:0] match_ie,
  input  logic [NUM_CAP-1:0]   cap_evt,
  input  logic [NUM_CAP-1:0]   cap_ie,
  input  logic                 wr_en,
  input  logic [NUM_FLAGS-1:0] wr_data,
  output tif_pkg::bit_cmd_t    cmd [NUM_FLAGS]
);
  logic [NUM_FLAGS-1:0] set_vec;

  // Match sources occupy the low bits and capture sources the upper bits.
  always_comb set_vec = {cap_evt & cap_ie, match_evt & match_ie};

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_cmd
    always_comb begin
      cmd[i].set = set_vec[i];
      cmd[i].clr = wr_en & wr_data[i];
    end
  end
endmodule

// File: rtl/tif_flag_bank.sv
module tif_flag_bank #(
  parameter int unsigned NUM_FLAGS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  tif_pkg::bit_cmd_t    cmd [NUM_FLAGS],
  output logic [NUM_FLAGS-1:0] flag_d,
  output logic [NUM_FLAGS-1:0] flag_q
);
  // Each bit owns its own register, so an access to one bit cannot
  // disturb any other bit.
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_bit
    always_comb flag_d[i] = tif_pkg::flag_next(flag_q[i], cmd[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d[i];
    end
  end
endmodule

// File: rtl/tif_irq_reduce.sv
module tif_irq_reduce #(
  parameter int unsigned NUM_FLAGS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] flag_d,
  output logic                 irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |flag_d;
  end
endmodule

// File: rtl/timer_irq_flags.sv
module timer_irq_flags #(
  parameter int unsigned NUM_MATCH = tif_pkg::DEF_MATCH,
  parameter int unsigned NUM_CAP   = tif_pkg::DEF_CAP,
  localparam int unsigned NUM_FLAGS = NUM_MATCH + NUM_CAP
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_MATCH-1:0] match_evt,
  input  logic [NUM_MATCH-1:0] match_ie,
  input  logic [NUM_CAP-1:0]   cap_evt,
  input  logic [NUM_CAP-1:0]   cap_ie,
  input  logic                 wr_en,
  input  logic [NUM_FLAGS-1:0] wr_data,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irq
);
  tif_pkg::bit_cmd_t    cmd [NUM_FLAGS];
  logic [NUM_FLAGS-1:0] flag_d;

  tif_evt_gate #(.NUM_MATCH(NUM_MATCH), .NUM_CAP(NUM_CAP)) u_gate (
    .match_evt(match_evt), .match_ie(match_ie),
    .cap_evt(cap_evt), .cap_ie(cap_ie),
    .wr_en(wr_en), .wr_data(wr_data), .cmd(cmd)
  );

  tif_flag_bank #(.NUM_FLAGS(NUM_FLAGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .flag_d(flag_d), .flag_q(flags)
  );

  tif_irq_reduce #(.NUM_FLAGS(NUM_FLAGS)) u_irq (
    .clk(clk), .rst_n(rst_n), .flag_d(flag_d), .irq(irq)
  );
endmodule

// File: rtl/tif_chk.sv
module tif_chk #(
  parameter int unsigned NUM_MATCH = 4,
  parameter int unsigned NUM_CAP   = 4,
  localparam int unsigned NUM_FLAGS = NUM_MATCH + NUM_CAP
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_MATCH-1:0] match_evt,
  input logic [NUM_MATCH-1:0] match_ie,
  input logic [NUM_CAP-1:0]   cap_evt,
  input logic [NUM_CAP-1:0]   cap_ie,
  input logic                 wr_en,
  input logic [NUM_FLAGS-1:0] wr_data,
  input logic [NUM_FLAGS-1:0] flags,
  input logic                 irq
);
  logic [NUM_FLAGS-1:0] setv, clrv;
  always_comb begin
    setv = {cap_evt & cap_ie, match_evt & match_ie};
    clrv = wr_en ? wr_data : '0;
  end

  // R2 R6 R7 R8
  set_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setv != '0) |=> ((flags & $past(setv)) == $past(setv)));

  // R3
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((flags & ~$past(flags) & ~$past(setv)) == '0));

  // R4
  clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clrv & ~setv) != '0) |=> ((flags & $past(clrv & ~setv)) == '0));

  // R5
  untouched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(setv | clrv)) == ($past(flags) & ~$past(setv | clrv))));

  // R9
  irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq == (|flags)));
endmodule

bind timer_irq_flags tif_chk #(.NUM_MATCH(NUM_MATCH), .NUM_CAP(NUM_CAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .match_evt(match_evt), .match_ie(match_ie),
  .cap_evt(cap_evt), .cap_ie(cap_ie), .wr_en(wr_en), .wr_data(wr_data),
  .flags(flags), .irq(irq)
);

// File: tb/test_timer_irq_flags.sv
module test_timer_irq_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] match_evt = '0, match_ie = '0, cap_evt = '0, cap_ie = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] flags;
  logic       irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  timer_irq_flags i_timer_irq_flags (
    .clk(clk), .rst_n(rst_n), .match_evt(match_evt), .match_ie(match_ie),
    .cap_evt(cap_evt), .cap_ie(cap_ie), .wr_en(wr_en), .wr_data(wr_data),
    .flags(flags), .irq(irq)
  );

  task automatic check(string req, logic [7:0] exp);
    total++;
    if (flags !== exp || irq !== (|exp)) begin
      bad++;
      $display("FAIL %s flags=%h irq=%b expected flags=%h irq=%b", req, flags, irq, exp, |exp);
    end
  endtask

  // One clock: apply set vector s with enables e and clear write w, then sample.
  task automatic step(logic [7:0] s, logic [7:0] e, logic we, logic [7:0] w);
    match_evt = s[3:0]; cap_evt = s[7:4];
    match_ie = e[3:0];  cap_ie = e[7:4];
    wr_en = we; wr_data = w;
    @(posedge clk); #1;
    match_evt = '0; cap_evt = '0; wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] pv, s, e, w, exp;
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", 8'h00);
    rst_n = 1'b1;
    @(posedge clk); #1 check("R1 after reset", 8'h00);

    // R2: each source sets its own bit
    for (int i = 0; i < 8; i++) begin
      step(8'h01 << i, 8'hFF, 1'b0, 8'h00);
      check("R2 source mapping", 8'h01 << i);
      step(8'h00, 8'hFF, 1'b1, 8'hFF);
      check("R4 clear all", 8'h00);
    end
    // R3: disabled events ignored
    step(8'hFF, 8'h00, 1'b0, 8'h00);
    check("R3 disabled events", 8'h00);
    step(8'hFF, 8'hA5, 1'b0, 8'h00);
    check("R3 partial enables", 8'hA5);
    // R5: zero bits and idle write have no effect
    step(8'h00, 8'hFF, 1'b1, 8'h00);
    check("R5 write zero", 8'hA5);
    step(8'h00, 8'hFF, 1'b0, 8'hFF);
    check("R5 wr_en low", 8'hA5);
    step(8'h00, 8'hFF, 1'b1, 8'h05);
    check("R4 partial clear", 8'hA0);
    step(8'h00, 8'hFF, 1'b1, 8'hFF);
    // R6: clear bit0 while bit1 set
    step(8'h01, 8'hFF, 1'b0, 8'h00);
    step(8'h02, 8'hFF, 1'b1, 8'h01);
    check("R6 clear bit0 set bit1", 8'h02);
    // R7: same bit set and clear
    step(8'h02, 8'hFF, 1'b1, 8'h02);
    check("R7 set wins", 8'h02);
    // R8: capture during match clear
    step(8'h0F, 8'hFF, 1'b0, 8'h00);
    step(8'h10, 8'hFF, 1'b1, 8'h0F);
    check("R8 capture during match clear", 8'h10);
    // R10: channel keeps working after a collision
    step(8'h00, 8'hFF, 1'b1, 8'hFF);
    check("R10 cleared after collision", 8'h00);
    step(8'h02, 8'hFF, 1'b0, 8'h00);
    check("R10 bit1 re-raised", 8'h02);
    step(8'h00, 8'hFF, 1'b1, 8'h02);
    step(8'h10, 8'hFF, 1'b0, 8'h00);
    check("R10 capture re-raised", 8'h10);

    // Sweep: starting pattern x every clear mask, with gated events (R4 R5 R6 R7 R9)
    for (int p = 0; p < 16; p++) begin
      pv = 8'(p * 17);
      for (int wi = 0; wi < 256; wi++) begin
        w = 8'(wi);
        s = 8'(wi * 5 + p * 3);
        e = ~8'(wi * 3 + p);
        step(8'h00, 8'hFF, 1'b1, 8'hFF);
        step(pv, 8'hFF, 1'b0, 8'h00);
        step(s, e, 1'b1, w);
        exp = (pv & ~w) | (s & e);
        check("R9 sweep", exp);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule